// File: doc/BRIEF.md
# Clock-Output Stop Controller

This block sits in front of a group of clock outputs and turns them off one at a time without cutting a pulse short. It runs on a fast sampling clock. Two source phases come in as sampled levels: one for the bus-clock group and one for the core-clock group. The bus group has free-running outputs and stoppable outputs. The core group drives true/complement pairs. Each gated output is a registered copy of its source phase, one sampling clock later, whenever its gate is open.

Two active-low halt pins request a stop: one for the stoppable bus outputs and one for the core pairs. The pins act only while the halt-pin enable input is high. All three pins pass through a two-stage synchronizer. The synchronized bus halt request is captured on each rising edge of the bus phase. The core halt request must be seen on two consecutive rising edges of the core phase before it takes effect. A per-output enable vector from the register file can also close any gate.

A gate opens or closes only while its source phase is low. This gives whole high pulses and a clean restart. A closed single-ended output rests low. A closed pair rests with true low and complement high.

Top module: `clkstop_ctrl`

## Requirements
- R1: While reset is high, every single-ended output and every pair true output reads 0, and every pair complement reads 1. Every gate comes out of reset closed and opens at the first low source phase after reset.
- R2: The halt-pin and halt inputs pass through two sampling-clock stages. The synchronized bus halt request is captured on each rising edge of the bus phase. Once a request is captured, every stoppable bus output finishes its current high phase and then stays low.
- R3: Free-running bus outputs keep following the bus phase whatever the halt pins do.
- R4: The synchronized core halt request takes effect only after it has been captured on two rising edges of the core phase. The affected pairs then stop at their next falling transition.
- R5: A stopped or disabled pair rests with true = 0 and complement = 1. A running pair always drives complement = NOT true.
- R6: While halt_pin_en is 0, both halt pins have no effect. The outputs keep toggling even with the pins held low.
- R7: Clearing an output's enable bit (bit i of io_free_en, io_en or core_en controls output i) holds that single-ended output at 0, or parks that pair. Setting the bit again restarts the output. A change to an enable bit takes effect only during a low source phase.
- R8: Every high pulse on an output lasts exactly one full source high phase. This includes the first pulse after a restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| io_ph | input | 1 | Bus-group source phase level |
| core_ph | input | 1 | Core-group source phase level |
| halt_pin_en | input | 1 | 1 lets the halt pins act |
| io_halt_n | input | 1 | Active-low stop request for stoppable bus outputs |
| core_halt_n | input | 1 | Active-low stop request for core pairs |
| io_free_en | input | N_FREE | Enable per free-running bus output |
| io_en | input | N_STOP | Enable per stoppable bus output |
| core_en | input | N_PAIR | Enable per core pair |
| io_free_clk | output | N_FREE | Gated free-running bus clocks |
| io_clk | output | N_STOP | Gated stoppable bus clocks |
| core_t | output | N_PAIR | Pair true levels |
| core_c | output | N_PAIR | Pair complement levels |

## Verification
The bench targets three timing cases:
- **Stop requests of one to a dozen cycles at shifting phase offsets.** A design that skips the synchronizer delay, or samples on the wrong edge, stops a cycle or a pulse early. So does a core stop that takes effect after only one edge.
- **Enable changes in the middle of a high phase.** A gate that updates while the phase is high produces a short pulse. A pulse-width monitor on every output catches it.
- **Halt-pin enable and pair parking.** The bench holds both halt pins low with halt_pin_en off to catch a design that ignores the enable. It also checks that a parked pair rests with true low and complement high, so a design that parks it with the levels swapped or left floating fails.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

    localparam int IO_FREE_NUM   = 2;
    localparam int IO_STOP_NUM   = 6;
    localparam int CORE_PAIR_NUM = 2;
    localparam int SYNC_STAGES   = 2;
    localparam int IO_EDGES      = 1;
    localparam int CORE_EDGES    = 2;

    typedef struct packed {
        logic pin_en;
        logic io_halt_n;
        logic core_halt_n;
    } pin_bundle_t;

    localparam pin_bundle_t PINS_IDLE = '{pin_en: 1'b0, io_halt_n: 1'b1, core_halt_n: 1'b1};

    typedef struct packed {
        logic io;
        logic core;
    } halt_req_t;

    function automatic halt_req_t decode_pins(pin_bundle_t p);
        halt_req_t r;
        r.io   = p.pin_en & ~p.io_halt_n;
        r.core = p.pin_en & ~p.core_halt_n;
        return r;
    endfunction

    function automatic logic gate_allow(logic en, logic halted);
        return en & ~halted;
    endfunction

endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
    parameter int W = 3,
    parameter int DEPTH = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stg [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d_i;
            for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
        end
    end

    assign q_o = stg[DEPTH-1];

endmodule

// File: rtl/clkstop_sampler.sv
module clkstop_sampler #(
    parameter int EDGES = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic ph_i,
    input  logic req_i,
    output logic halt_o
);

    logic             ph_q;
    logic             rise;
    logic [EDGES-1:0] hist;

    assign rise = ph_i & ~ph_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q <= 1'b0;
            hist <= '0;
        end else begin
            ph_q <= ph_i;
            if (rise) begin
                hist[0] <= req_i;
                for (int i = 1; i < EDGES; i++) hist[i] <= hist[i-1];
            end
        end
    end

    assign halt_o = hist[EDGES-1];

    // R2 / R4: the halt state moves only on a source rising edge
    assert_halt_on_rise_R4: assert property (@(posedge clk) disable iff (rst)
        (halt_o != $past(halt_o)) |-> ($past(ph_i) && !$past(ph_q)));

endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate (
    input  logic clk,
    input  logic rst,
    input  logic ph_i,
    input  logic allow_i,
    output logic t_o,
    output logic c_o
);

    logic open_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            t_o    <= 1'b0;
            c_o    <= 1'b1;
        end else begin
            if (!ph_i) open_q <= allow_i;
            t_o <= ph_i & open_q;
            c_o <= ~(ph_i & open_q);
        end
    end

    // R8: a high pulse ends only because the source phase ended
    assert_no_short_high_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(t_o) |-> !$past(ph_i));

    // R8: a high pulse starts only at the start of a source high phase
    assert_no_late_start_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(t_o) |-> !$past(ph_i, 2));

    // R5: complement is always the opposite level of true
    assert_pair_split_R5: assert property (@(posedge clk) disable iff (rst)
        t_o != c_o);

endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
    import clkstop_pkg::*;
#(
    parameter int N_FREE     = IO_FREE_NUM,
    parameter int N_STOP     = IO_STOP_NUM,
    parameter int N_PAIR     = CORE_PAIR_NUM,
    parameter int SYNC_DEPTH = SYNC_STAGES,
    parameter int IO_SAMPLES = IO_EDGES,
    parameter int CORE_SAMPLES = CORE_EDGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_ph,
    input  logic              core_ph,
    input  logic              halt_pin_en,
    input  logic              io_halt_n,
    input  logic              core_halt_n,
    input  logic [N_FREE-1:0] io_free_en,
    input  logic [N_STOP-1:0] io_en,
    input  logic [N_PAIR-1:0] core_en,
    output logic [N_FREE-1:0] io_free_clk,
    output logic [N_STOP-1:0] io_clk,
    output logic [N_PAIR-1:0] core_t,
    output logic [N_PAIR-1:0] core_c
);

    localparam int PIN_W = $bits(pin_bundle_t);

    pin_bundle_t pins_raw;
    pin_bundle_t pins_sync;
    halt_req_t   req;
    logic        io_halted;
    logic        core_halted;
    logic [N_FREE-1:0] unused_free_c;
    logic [N_STOP-1:0] unused_io_c;

    assign pins_raw = '{pin_en: halt_pin_en, io_halt_n: io_halt_n, core_halt_n: core_halt_n};

    clkstop_sync #(.W(PIN_W), .DEPTH(SYNC_DEPTH), .RST_VAL(PINS_IDLE)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (pins_raw),
        .q_o (pins_sync)
    );

    assign req = decode_pins(pins_sync);

    clkstop_sampler #(.EDGES(IO_SAMPLES)) u_io_samp (
        .clk    (clk),
        .rst    (rst),
        .ph_i   (io_ph),
        .req_i  (req.io),
        .halt_o (io_halted)
    );

    clkstop_sampler #(.EDGES(CORE_SAMPLES)) u_core_samp (
        .clk    (clk),
        .rst    (rst),
        .ph_i   (core_ph),
        .req_i  (req.core),
        .halt_o (core_halted)
    );

    for (genvar i = 0; i < N_FREE; i++) begin : g_free
        clkstop_gate u_gate (
            .clk     (clk),
            .rst     (rst),
            .ph_i    (io_ph),
            .allow_i (io_free_en[i]),
            .t_o     (io_free_clk[i]),
            .c_o     (unused_free_c[i])
        );
    end

    for (genvar i = 0; i < N_STOP; i++) begin : g_stop
        clkstop_gate u_gate (
            .clk     (clk),
            .rst     (rst),
            .ph_i    (io_ph),
            .allow_i (gate_allow(io_en[i], io_halted)),
            .t_o     (io_clk[i]),
            .c_o     (unused_io_c[i])
        );
    end

    for (genvar i = 0; i < N_PAIR; i++) begin : g_pair
        clkstop_gate u_gate (
            .clk     (clk),
            .rst     (rst),
            .ph_i    (core_ph),
            .allow_i (gate_allow(core_en[i], core_halted)),
            .t_o     (core_t[i]),
            .c_o     (core_c[i])
        );
    end

    // R6: a bus halt can be captured only while the synchronized pin enable is set
    assert_pins_gated_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(io_halted) |-> $past(pins_sync.pin_en));

endmodule

// File: tb/clkstop_ctrl_tb_top.sv
module clkstop_ctrl_tb_top;
    import clkstop_pkg::*;

    localparam int NF = IO_FREE_NUM;
    localparam int NS = IO_STOP_NUM;
    localparam int NC = CORE_PAIR_NUM;
    localparam int IO_HALF = 4;
    localparam int CORE_HALF = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic io_ph = 1'b0, core_ph = 1'b0;
    logic halt_pin_en = 1'b1, io_halt_n = 1'b1, core_halt_n = 1'b1;
    logic [NF-1:0] io_free_en = '1;
    logic [NS-1:0] io_en = '1;
    logic [NC-1:0] core_en = '1;
    logic [NF-1:0] io_free_clk;
    logic [NS-1:0] io_clk;
    logic [NC-1:0] core_t, core_c;

    clkstop_ctrl dut_i (
        .clk(clk), .rst(rst), .io_ph(io_ph), .core_ph(core_ph),
        .halt_pin_en(halt_pin_en), .io_halt_n(io_halt_n), .core_halt_n(core_halt_n),
        .io_free_en(io_free_en), .io_en(io_en), .core_en(core_en),
        .io_free_clk(io_free_clk), .io_clk(io_clk), .core_t(core_t), .core_c(core_c)
    );

    int vectors = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        end
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    // source phases
    always @(negedge clk) begin
        cyc++;
        io_ph = (cyc % (2 * IO_HALF)) < IO_HALF;
        core_ph = (cyc % (2 * CORE_HALF)) < CORE_HALF;
    end

    // behavioural reference model
    bit q_io[$];
    bit q_core[$];
    bit last_io, last_core, io_hold, core_a, core_b;
    bit open_f[NF];
    bit open_s[NS];
    bit open_c[NC];
    logic [NF-1:0] e_free;
    logic [NS-1:0] e_io;
    logic [NC-1:0] e_t, e_c;

    always @(posedge clk) begin
        if (rst) begin
            q_io = {1'b0, 1'b0};
            q_core = {1'b0, 1'b0};
            last_io = 0; last_core = 0; io_hold = 0; core_a = 0; core_b = 0;
            foreach (open_f[i]) open_f[i] = 0;
            foreach (open_s[i]) open_s[i] = 0;
            foreach (open_c[i]) open_c[i] = 0;
            e_free = '0; e_io = '0; e_t = '0; e_c = '1;
        end else begin
            for (int i = 0; i < NF; i++) e_free[i] = io_ph & open_f[i];
            for (int i = 0; i < NS; i++) e_io[i] = io_ph & open_s[i];
            for (int i = 0; i < NC; i++) begin
                e_t[i] = core_ph & open_c[i];
                e_c[i] = !e_t[i];
            end
            if (!io_ph) begin
                for (int i = 0; i < NF; i++) open_f[i] = io_free_en[i];
                for (int i = 0; i < NS; i++) open_s[i] = io_en[i] && !io_hold;
            end
            if (!core_ph)
                for (int i = 0; i < NC; i++) open_c[i] = core_en[i] && !core_b;
            if (io_ph && !last_io) io_hold = q_io[$-1];
            if (core_ph && !last_core) begin
                core_b = core_a;
                core_a = q_core[$-1];
            end
            last_io = io_ph;
            last_core = core_ph;
            q_io.push_back(halt_pin_en && !io_halt_n);
            q_core.push_back(halt_pin_en && !core_halt_n);
            if (q_io.size() > 4) void'(q_io.pop_front());
            if (q_core.size() > 4) void'(q_core.pop_front());
        end
    end

    // per-cycle compare and pulse-width monitor
    int run_f[NF];
    int run_s[NS];
    int run_c[NC];
    int rises_free = 0, rises_io = 0, rises_core = 0;
    logic prev_f0 = 0, prev_s0 = 0, prev_c0 = 0;

    always @(negedge clk) begin
        if (rst) begin
            foreach (run_f[i]) run_f[i] = 0;
            foreach (run_s[i]) run_s[i] = 0;
            foreach (run_c[i]) run_c[i] = 0;
            prev_f0 = 0; prev_s0 = 0; prev_c0 = 0;
        end else if (!finished) begin
            chk(io_clk === e_io, "R2 stoppable bus outputs", io_clk, e_io);
            chk(io_free_clk === e_free, "R3 free-running outputs", io_free_clk, e_free);
            chk(core_t === e_t, "R4 pair true levels", core_t, e_t);
            chk(core_c === e_c, "R5 pair complement levels", core_c, e_c);
            for (int i = 0; i < NF; i++) begin
                if (io_free_clk[i]) run_f[i]++;
                else if (run_f[i] != 0) begin
                    chk(run_f[i] == IO_HALF, "R8 free pulse width", run_f[i], IO_HALF);
                    run_f[i] = 0;
                end
            end
            for (int i = 0; i < NS; i++) begin
                if (io_clk[i]) run_s[i]++;
                else if (run_s[i] != 0) begin
                    chk(run_s[i] == IO_HALF, "R8 bus pulse width", run_s[i], IO_HALF);
                    run_s[i] = 0;
                end
            end
            for (int i = 0; i < NC; i++) begin
                if (core_t[i]) run_c[i]++;
                else if (run_c[i] != 0) begin
                    chk(run_c[i] == CORE_HALF, "R8 pair pulse width", run_c[i], CORE_HALF);
                    run_c[i] = 0;
                end
            end
            if (io_free_clk[0] && !prev_f0) rises_free++;
            if (io_clk[0] && !prev_s0) rises_io++;
            if (core_t[0] && !prev_c0) rises_core++;
            prev_f0 = io_free_clk[0];
            prev_s0 = io_clk[0];
            prev_c0 = core_t[0];
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual %0d expected %0d", cyc, 0);
            summary();
            $finish;
        end
    end

    initial begin
        int r0, r1;
        run(3);
        chk(io_clk == '0 && io_free_clk == '0, "R1 reset single-ended", {io_clk, io_free_clk}, 0);
        chk(core_t == '0 && core_c == '1, "R1 reset pairs", {core_t, core_c}, {{NC{1'b0}}, {NC{1'b1}}});
        rst = 1'b0;
        run(40);

        // bus halt
        io_halt_n = 1'b0;
        run(24);
        r0 = rises_free;
        run(16);
        chk(io_clk == '0, "R2 stoppable outputs held low", io_clk, 0);
        chk(rises_free > r0, "R3 free output still toggles", rises_free, r0 + 1);
        io_halt_n = 1'b1;
        run(30);

        // core halt
        core_halt_n = 1'b0;
        run(30);
        chk(core_t == '0 && core_c == '1, "R5 parked pair", {core_t, core_c}, {{NC{1'b0}}, {NC{1'b1}}});
        core_halt_n = 1'b1;
        run(30);

        // halt pins disabled
        halt_pin_en = 1'b0;
        run(4);
        io_halt_n = 1'b0;
        core_halt_n = 1'b0;
        r0 = rises_io;
        r1 = rises_core;
        run(40);
        chk(rises_io > r0, "R6 bus output ignores halt", rises_io, r0 + 1);
        chk(rises_core > r1, "R6 pair ignores halt", rises_core, r1 + 1);
        halt_pin_en = 1'b1;
        run(40);
        chk(io_clk == '0, "R6 halt acts once enabled", io_clk, 0);
        io_halt_n = 1'b1;
        core_halt_n = 1'b1;
        run(30);

        // enable bits changed at every phase offset
        for (int off = 0; off < 8; off++) begin
            run(off + 1);
            io_en[off % NS] = 1'b0;
            io_free_en[off % NF] = 1'b0;
            core_en[off % NC] = 1'b0;
            run(24);
            chk(io_clk[off % NS] == 1'b0, "R7 disabled bus output low", io_clk, 0);
            chk(io_free_clk[off % NF] == 1'b0, "R7 disabled free output low", io_free_clk, 0);
            chk(core_t[off % NC] == 1'b0 && core_c[off % NC] == 1'b1, "R7 disabled pair parked",
                {core_t, core_c}, 0);
            io_en = '1;
            io_free_en = '1;
            core_en = '1;
            run(13);
        end

        // short and long halt pulses at shifting offsets
        for (int len = 1; len <= 12; len++) begin
            io_halt_n = 1'b0;
            run(len);
            io_halt_n = 1'b1;
            core_halt_n = 1'b0;
            run(len + 1);
            core_halt_n = 1'b1;
            run(7 + len);
        end
        run(20);
        summary();
        $finish;
    end

endmodule